// File: doc/BRIEF.md
# Multidrop Wakeup Receiver

This block receives asynchronous serial characters on a shared multidrop line and decides, in hardware, which of them the local node should see. It accepts two character lengths: a 10-bit character (start, eight data bits sent least significant first, stop) and an 11-bit character that adds a ninth bit after the data, where a ninth bit of 1 tags the character as an address and 0 tags it as data. The line is resynchronised to the core clock and each bit is sampled once, in the middle of its period, using a 16x oversample tick supplied from outside.

Software can put the receiver to sleep to skip the rest of a message that is not meant for it. While asleep, no character is delivered and no receive or address interrupt is raised. The receiver wakes on one of two selectable events: an idle line lasting a full character time, or an address-tagged character. After waking, the first character (the header) is compared against the node's own address and a broadcast address. A match keeps the receiver awake and delivers the header; a mismatch sends it straight back to sleep. While awake in 11-bit mode, any address-tagged character is treated as a new header, so back-to-back messages need no idle gap.

Top module: `mdrop_rx`

## Requirements
- R1: After reset, rx_valid, rx_irq, idle_irq and addr_irq are 0, rx_data is 0 and sleeping is 0.
- R2: With frame11=0, a character sent as start (0), eight data bits least significant first, stop (1) gives one rx_valid pulse with rx_data equal to the byte, rx_addr=0 and rx_ferr=0, plus one rx_irq pulse when rx_ie=1.
- R3: With frame11=1, the bit after the data MSB is copied to rx_addr; a delivered character with rx_addr=1 gives one addr_irq pulse when addr_ie=1, and one with rx_addr=0 gives none.
- R4: A low level on the line that has returned high by the middle of the start bit is dropped without delivering anything.
- R5: A stop bit sampled low still delivers the byte, with rx_ferr=1; a new start is only accepted after the line has been seen high again.
- R6: A one-cycle pulse on sleep_req sets sleeping=1; while asleep, characters give no rx_valid, rx_irq or addr_irq.
- R7: With wake_sel=0, once a character has ended, a run of marks lasting one full character time (10 or 11 bit times from the middle of the stop bit) clears sleeping; when awake and idle_ie=1 the same detection gives an idle_irq pulse.
- R8: With wake_sel=1, only a character with ninth bit 1 wakes the receiver; data characters and idle lines leave sleeping at 1.
- R9: The header after a wakeup, and any address-tagged character while awake, is delivered only if it equals node_addr or bcast_addr; otherwise it is dropped and sleeping becomes 1. Characters after an accepted header are delivered without comparison.
- R10: With rx_en=0, nothing is received and no idle line is detected.
- R11: With rx_ie=0 a delivered character still pulses rx_valid but raises no rx_irq.
- R12: One idle period gives at most one idle detection; another character must end before the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| os_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| frame11 | input | 1 | 1: 11-bit character with address bit, 0: 10-bit character |
| wake_sel | input | 1 | Wake source: 0 idle line, 1 address-tagged character |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| rx_ie | input | 1 | Receive interrupt enable |
| idle_ie | input | 1 | Idle-line interrupt enable |
| addr_ie | input | 1 | Address interrupt enable |
| node_addr | input | 8 | Node's own address |
| bcast_addr | input | 8 | Broadcast address |
| rx_data | output | 8 | Last delivered byte |
| rx_addr | output | 1 | Ninth bit of the last delivered character |
| rx_ferr | output | 1 | Framing error of the last delivered character |
| rx_valid | output | 1 | One-cycle pulse per delivered character |
| rx_irq | output | 1 | Receive interrupt pulse |
| idle_irq | output | 1 | Idle-line interrupt pulse |
| addr_irq | output | 1 | Address interrupt pulse |
| sleeping | output | 1 | Receiver is asleep |

## Verification
The bench targets the wake paths separately: a character sent while asleep in idle-wake mode must stay hidden, while the idle gap after it must wake the node; a design that woke on any character, or never rearmed the idle detector, would deliver or stay asleep. Header comparison is driven with a matching, a broadcast and a foreign address, so a design that delivered mismatched headers or forgot to fall back asleep shows up as an extra rx_valid or a wrong sleeping level. A glitch shorter than half a bit and a low stop bit probe the sampler, where a design sampling at the edge would deliver a spurious byte or a design resuming on the low stop would manufacture a second character. Address-wake mode is checked against an idle gap that must not wake it and against a foreign address arriving mid-message with no gap.

// File: rtl/mdr_pkg.sv
package mdr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_SHIFT = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  localparam int unsigned MDR_NUM_MATCH = 2;

endpackage

// File: rtl/mdr_sync.sv
module mdr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_n;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/mdr_frame_rx.sv
module mdr_frame_rx
  import mdr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              en,
  input  logic              frame11,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              ninth,
  output logic              stop_ok
);

  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned BCW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] MID     = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_OS = CW'(OSR - 1);

  rx_state_e         st_q, st_n;
  logic [CW-1:0]     os_q, os_n;
  logic [BCW-1:0]    bit_q, bit_n, last_bit;
  logic [DATA_W:0]   sh_q, sh_n;
  logic              m11_q, m11_n;
  logic              mark_q, mark_n;
  logic              done_q, done_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              ninth_q, ninth_n;
  logic              stop_q, stop_n;

  always_comb begin
    st_n     = st_q;
    os_n     = os_q;
    bit_n    = bit_q;
    sh_n     = sh_q;
    m11_n    = m11_q;
    mark_n   = mark_q;
    done_n   = 1'b0;
    data_n   = data_q;
    ninth_n  = ninth_q;
    stop_n   = stop_q;
    last_bit = m11_q ? BCW'(DATA_W) : BCW'(DATA_W - 1);
    if (!en) begin
      st_n   = ST_IDLE;
      mark_n = 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (rxd) begin
            mark_n = 1'b1;
          end else if (tick && mark_q) begin
            st_n   = ST_START;
            os_n   = '0;
            mark_n = 1'b0;
            m11_n  = frame11;
          end
        end
        ST_START: begin
          if (tick) begin
            if (os_q == MID) begin
              if (rxd) begin
                st_n = ST_IDLE;
              end else begin
                st_n  = ST_SHIFT;
                os_n  = '0;
                bit_n = '0;
              end
            end else begin
              os_n = os_q + 1'b1;
            end
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (os_q == LAST_OS) begin
              os_n  = '0;
              sh_n  = {rxd, sh_q[DATA_W:1]};
              bit_n = bit_q + 1'b1;
              if (bit_q == last_bit) st_n = ST_STOP;
            end else begin
              os_n = os_q + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (os_q == LAST_OS) begin
              done_n  = 1'b1;
              stop_n  = rxd;
              data_n  = m11_q ? sh_q[DATA_W-1:0] : sh_q[DATA_W:1];
              ninth_n = m11_q & sh_q[DATA_W];
              st_n    = ST_IDLE;
              os_n    = '0;
            end else begin
              os_n = os_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      os_q    <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      m11_q   <= 1'b0;
      mark_q  <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      ninth_q <= 1'b0;
      stop_q  <= 1'b1;
    end else begin
      st_q    <= st_n;
      os_q    <= os_n;
      bit_q   <= bit_n;
      sh_q    <= sh_n;
      m11_q   <= m11_n;
      mark_q  <= mark_n;
      done_q  <= done_n;
      data_q  <= data_n;
      ninth_q <= ninth_n;
      stop_q  <= stop_n;
    end
  end

  assign done    = done_q;
  assign data    = data_q;
  assign ninth   = ninth_q;
  assign stop_ok = stop_q;

  // R2: a completed character only follows a stop-bit sample on a tick
  p_done_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(st_q == ST_STOP && tick));

  // R4: a start that reads high at mid-bit never reaches the data phase
  p_false_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && tick && os_q == MID && rxd && en) |=> (st_q == ST_IDLE));

  // R5: no new character begins without a mark seen since the last one
  p_mark_before_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !mark_q) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/mdr_idle_det.sv
module mdr_idle_det #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  input  logic en,
  input  logic frame11,
  input  logic arm,
  output logic det
);

  localparam int unsigned IW = $clog2((DATA_W + 3) * OSR + 1);
  localparam logic [IW-1:0] LIM10 = IW'((DATA_W + 2) * OSR - 1);
  localparam logic [IW-1:0] LIM11 = IW'((DATA_W + 3) * OSR - 1);

  logic [IW-1:0] cnt_q, cnt_n, lim;
  logic          armed_q, armed_n;
  logic          det_q, det_n;

  always_comb begin
    cnt_n   = cnt_q;
    armed_n = armed_q;
    det_n   = 1'b0;
    lim     = frame11 ? LIM11 : LIM10;
    if (!en) begin
      armed_n = 1'b0;
      cnt_n   = '0;
    end else if (arm) begin
      armed_n = 1'b1;
      cnt_n   = '0;
    end else if (armed_q) begin
      if (!rxd) begin
        cnt_n = '0;
      end else if (tick) begin
        if (cnt_q == lim) begin
          det_n   = 1'b1;
          armed_n = 1'b0;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      det_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      armed_q <= armed_n;
      det_q   <= det_n;
    end
  end

  assign det = det_q;

  // R12: one detection per idle period
  p_idle_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    det_q |=> !det_q);

  // R10: nothing is detected while the receiver is disabled
  p_idle_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    det_q |-> $past(en));

endmodule

// File: rtl/mdr_wake_ctl.sv
module mdr_wake_ctl
  import mdr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              f_done,
  input  logic [DATA_W-1:0] f_data,
  input  logic              f_ninth,
  input  logic              f_stop_ok,
  input  logic              idle_det,
  input  logic              sleep_req,
  input  logic              wake_sel,
  input  logic [DATA_W-1:0] node_addr,
  input  logic [DATA_W-1:0] bcast_addr,
  input  logic              rx_ie,
  input  logic              idle_ie,
  input  logic              addr_ie,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_addr,
  output logic              rx_ferr,
  output logic              rx_valid,
  output logic              rx_irq,
  output logic              idle_irq,
  output logic              addr_irq,
  output logic              sleeping
);

  logic [MDR_NUM_MATCH-1:0][DATA_W-1:0] match_tab;
  logic [MDR_NUM_MATCH-1:0]             hit;

  assign match_tab[0] = node_addr;
  assign match_tab[1] = bcast_addr;

  for (genvar i = 0; i < MDR_NUM_MATCH; i++) begin : g_cmp
    assign hit[i] = (f_data == match_tab[i]);
  end

  logic              sleep_q, sleep_n;
  logic              hdr_q, hdr_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              addr_q, addr_n;
  logic              ferr_q, ferr_n;
  logic              valid_q, valid_n;
  logic              rxirq_q, rxirq_n;
  logic              idleirq_q, idleirq_n;
  logic              addrirq_q, addrirq_n;
  logic              wake_now, awake_eff, is_hdr, accept, reject;

  always_comb begin
    wake_now  = sleep_q & ((!wake_sel & idle_det) | (wake_sel & f_done & f_ninth));
    awake_eff = !sleep_q | wake_now;
    is_hdr    = hdr_q | wake_now | f_ninth;
    accept    = f_done & awake_eff & (!is_hdr | (|hit));
    reject    = f_done & awake_eff & is_hdr & !(|hit);

    sleep_n = sleep_q;
    if (sleep_req)     sleep_n = 1'b1;
    else if (reject)   sleep_n = 1'b1;
    else if (wake_now) sleep_n = 1'b0;

    hdr_n = hdr_q;
    if (sleep_req)                  hdr_n = 1'b0;
    else if (f_done && awake_eff)   hdr_n = 1'b0;
    else if (wake_now)              hdr_n = 1'b1;

    data_n = data_q;
    addr_n = addr_q;
    ferr_n = ferr_q;
    if (accept) begin
      data_n = f_data;
      addr_n = f_ninth;
      ferr_n = !f_stop_ok;
    end
    valid_n   = accept;
    rxirq_n   = accept & rx_ie;
    addrirq_n = accept & f_ninth & addr_ie;
    idleirq_n = idle_det & idle_ie & !sleep_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q   <= 1'b0;
      hdr_q     <= 1'b0;
      data_q    <= '0;
      addr_q    <= 1'b0;
      ferr_q    <= 1'b0;
      valid_q   <= 1'b0;
      rxirq_q   <= 1'b0;
      idleirq_q <= 1'b0;
      addrirq_q <= 1'b0;
    end else begin
      sleep_q   <= sleep_n;
      hdr_q     <= hdr_n;
      data_q    <= data_n;
      addr_q    <= addr_n;
      ferr_q    <= ferr_n;
      valid_q   <= valid_n;
      rxirq_q   <= rxirq_n;
      idleirq_q <= idleirq_n;
      addrirq_q <= addrirq_n;
    end
  end

  assign rx_data  = data_q;
  assign rx_addr  = addr_q;
  assign rx_ferr  = ferr_q;
  assign rx_valid = valid_q;
  assign rx_irq   = rxirq_q;
  assign idle_irq = idleirq_q;
  assign addr_irq = addrirq_q;
  assign sleeping = sleep_q;

  // R6: a delivery leaves the receiver awake unless sleep was just requested
  p_valid_awake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (!sleep_q || $past(sleep_req)));

  // R11: receive interrupt only with a delivery and its enable
  p_rx_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rxirq_q |-> (valid_q && $past(rx_ie)));

  // R3: address interrupt only for a delivered address character
  p_addr_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addrirq_q |-> (valid_q && addr_q));

  // R9: a delivered address character matched one of the two addresses
  p_addr_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && addr_q) |-> (data_q == $past(node_addr) || data_q == $past(bcast_addr)));

  // R7: the idle interrupt is only raised by an awake receiver
  p_idle_irq_awake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idleirq_q |-> $past(!sleep_q));

endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              frame11,
  input  logic              wake_sel,
  input  logic              sleep_req,
  input  logic              rx_ie,
  input  logic              idle_ie,
  input  logic              addr_ie,
  input  logic [DATA_W-1:0] node_addr,
  input  logic [DATA_W-1:0] bcast_addr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_addr,
  output logic              rx_ferr,
  output logic              rx_valid,
  output logic              rx_irq,
  output logic              idle_irq,
  output logic              addr_irq,
  output logic              sleeping
);

  logic              rst_sync_n;
  logic              rxd_s;
  logic              f_done, f_ninth, f_stop_ok, idle_det;
  logic [DATA_W-1:0] f_data;

  mdr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  mdr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(rxd), .q(rxd_s)
  );

  mdr_frame_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_sync_n), .tick(os_tick), .rxd(rxd_s), .en(rx_en),
    .frame11(frame11), .done(f_done), .data(f_data), .ninth(f_ninth),
    .stop_ok(f_stop_ok)
  );

  mdr_idle_det #(.DATA_W(DATA_W), .OSR(OSR)) u_idle (
    .clk(clk), .rst_n(rst_sync_n), .tick(os_tick), .rxd(rxd_s), .en(rx_en),
    .frame11(frame11), .arm(f_done), .det(idle_det)
  );

  mdr_wake_ctl #(.DATA_W(DATA_W)) u_wake (
    .clk(clk), .rst_n(rst_sync_n), .f_done(f_done), .f_data(f_data),
    .f_ninth(f_ninth), .f_stop_ok(f_stop_ok), .idle_det(idle_det),
    .sleep_req(sleep_req), .wake_sel(wake_sel), .node_addr(node_addr),
    .bcast_addr(bcast_addr), .rx_ie(rx_ie), .idle_ie(idle_ie), .addr_ie(addr_ie),
    .rx_data(rx_data), .rx_addr(rx_addr), .rx_ferr(rx_ferr), .rx_valid(rx_valid),
    .rx_irq(rx_irq), .idle_irq(idle_irq), .addr_irq(addr_irq), .sleeping(sleeping)
  );

endmodule

// File: tb/tb_mdrop_rx.sv
`timescale 1ns/1ps
module tb_mdrop_rx;

  localparam int BIT_CLKS = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_en = 1'b0, frame11 = 1'b0, wake_sel = 1'b0, sleep_req = 1'b0;
  logic       rx_ie = 1'b0, idle_ie = 1'b0, addr_ie = 1'b0;
  logic [7:0] node_addr = 8'h41, bcast_addr = 8'hFF;
  logic [7:0] rx_data;
  logic       rx_addr, rx_ferr, rx_valid, rx_irq, idle_irq, addr_irq, sleeping;

  int n_chk = 0, n_fail = 0;
  int n_valid = 0, n_rxirq = 0, n_idle = 0, n_addrirq = 0;
  int tdiv = 0;
  logic [7:0] last_data = '0;
  logic last_addr = 1'b0, last_ferr = 1'b0;

  mdrop_rx dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .rx_en(rx_en),
    .frame11(frame11), .wake_sel(wake_sel), .sleep_req(sleep_req), .rx_ie(rx_ie),
    .idle_ie(idle_ie), .addr_ie(addr_ie), .node_addr(node_addr),
    .bcast_addr(bcast_addr), .rx_data(rx_data), .rx_addr(rx_addr),
    .rx_ferr(rx_ferr), .rx_valid(rx_valid), .rx_irq(rx_irq),
    .idle_irq(idle_irq), .addr_irq(addr_irq), .sleeping(sleeping)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
    os_tick <= (tdiv == 3);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        n_valid   <= n_valid + 1;
        last_data <= rx_data;
        last_addr <= rx_addr;
        last_ferr <= rx_ferr;
      end
      if (rx_irq)   n_rxirq   <= n_rxirq + 1;
      if (idle_irq) n_idle    <= n_idle + 1;
      if (addr_irq) n_addrirq <= n_addrirq + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * BIT_CLKS) @(negedge clk);
    #1;
  endtask

  task automatic send_bit(input logic v);
    rxd = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic nine, input logic stopv);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (frame11) send_bit(nine);
    send_bit(stopv);
    rxd = 1'b1;
  endtask

  task automatic pulse_sleep();
    @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 idle_irq", idle_irq, 0);
    chk("R1 addr_irq", addr_irq, 0);
    chk("R1 rx_data", rx_data, 0);
    chk("R1 sleeping", sleeping, 0);
  endtask

  task automatic t_basic10();
    int v0, i0;
    v0 = n_valid; i0 = n_rxirq;
    rx_ie = 1'b1;
    send_frame(8'hA5, 1'b0, 1'b1);
    wait_bits(1);
    chk("R2 count", n_valid - v0, 1);
    chk("R2 data", last_data, 8'hA5);
    chk("R2 addr flag", last_addr, 0);
    chk("R2 ferr", last_ferr, 0);
    chk("R2 rx_irq", n_rxirq - i0, 1);
    send_frame(8'h3C, 1'b0, 1'b1);
    wait_bits(1);
    chk("R2 second data", last_data, 8'h3C);
    wait_bits(12);
  endtask

  task automatic t_ie_off();
    int v0, i0;
    v0 = n_valid; i0 = n_rxirq;
    rx_ie = 1'b0;
    send_frame(8'h96, 1'b0, 1'b1);
    wait_bits(1);
    chk("R11 valid", n_valid - v0, 1);
    chk("R11 no irq", n_rxirq - i0, 0);
    rx_ie = 1'b1;
    wait_bits(12);
  endtask

  task automatic t_idle();
    int d0;
    idle_ie = 1'b1;
    send_frame(8'h11, 1'b0, 1'b1);
    d0 = n_idle;
    wait_bits(12);
    chk("R7 idle irq", n_idle - d0, 1);
    wait_bits(12);
    chk("R12 single idle", n_idle - d0, 1);
  endtask

  task automatic t_false_start();
    int v0;
    v0 = n_valid;
    @(negedge clk);
    rxd = 1'b0;
    repeat (20) @(negedge clk);
    rxd = 1'b1;
    wait_bits(12);
    chk("R4 glitch dropped", n_valid - v0, 0);
  endtask

  task automatic t_ferr();
    int v0;
    v0 = n_valid;
    send_frame(8'h5A, 1'b0, 1'b0);
    wait_bits(2);
    chk("R5 delivered once", n_valid - v0, 1);
    chk("R5 data", last_data, 8'h5A);
    chk("R5 ferr", last_ferr, 1);
    wait_bits(12);
  endtask

  task automatic t_addr11();
    int v0, a0;
    frame11 = 1'b1; addr_ie = 1'b1;
    v0 = n_valid; a0 = n_addrirq;
    send_frame(8'h41, 1'b1, 1'b1);
    wait_bits(1);
    chk("R3 addr count", n_valid - v0, 1);
    chk("R3 addr flag", last_addr, 1);
    chk("R3 addr irq", n_addrirq - a0, 1);
    send_frame(8'h42, 1'b0, 1'b1);
    wait_bits(1);
    chk("R3 data byte", last_data, 8'h42);
    chk("R3 data flag", last_addr, 0);
    chk("R3 no addr irq", n_addrirq - a0, 1);
    wait_bits(12);
    frame11 = 1'b0;
  endtask

  task automatic t_sleep_idle();
    int v0, i0;
    wake_sel = 1'b0;
    pulse_sleep();
    chk("R6 sleeping set", sleeping, 1);
    v0 = n_valid; i0 = n_rxirq;
    send_frame(8'h41, 1'b0, 1'b1);
    wait_bits(1);
    chk("R6 no valid asleep", n_valid - v0, 0);
    chk("R6 no irq asleep", n_rxirq - i0, 0);
    chk("R7 still asleep before gap", sleeping, 1);
    wait_bits(12);
    chk("R7 idle wakes", sleeping, 0);
    send_frame(8'h77, 1'b0, 1'b1);
    wait_bits(1);
    chk("R9 foreign header dropped", n_valid - v0, 0);
    chk("R9 foreign header sleeps", sleeping, 1);
    wait_bits(12);
    chk("R7 wakes again", sleeping, 0);
    send_frame(8'hFF, 1'b0, 1'b1);
    send_frame(8'h10, 1'b0, 1'b1);
    wait_bits(1);
    chk("R9 broadcast and data", n_valid - v0, 2);
    chk("R9 last data", last_data, 8'h10);
    chk("R9 awake after match", sleeping, 0);
    wait_bits(12);
  endtask

  task automatic t_sleep_addr();
    int v0, a0;
    frame11 = 1'b1; wake_sel = 1'b1;
    pulse_sleep();
    v0 = n_valid; a0 = n_addrirq;
    send_frame(8'h41, 1'b0, 1'b1);
    wait_bits(12);
    chk("R8 data does not wake", n_valid - v0, 0);
    chk("R8 idle does not wake", sleeping, 1);
    send_frame(8'h41, 1'b1, 1'b1);
    wait_bits(1);
    chk("R8 address wakes", sleeping, 0);
    chk("R8 header delivered", n_valid - v0, 1);
    chk("R8 addr irq", n_addrirq - a0, 1);
    send_frame(8'h23, 1'b0, 1'b1);
    send_frame(8'h99, 1'b1, 1'b1);
    wait_bits(1);
    chk("R9 data then foreign address", n_valid - v0, 2);
    chk("R9 foreign address sleeps", sleeping, 1);
    chk("R9 last data kept", last_data, 8'h23);
    wait_bits(12);
    frame11 = 1'b0; wake_sel = 1'b0;
  endtask

  task automatic t_disabled();
    int v0, d0;
    pulse_sleep();
    wake_sel = 1'b0;
    rx_en = 1'b0;
    v0 = n_valid; d0 = n_idle;
    send_frame(8'h41, 1'b0, 1'b1);
    wait_bits(14);
    chk("R10 nothing received", n_valid - v0, 0);
    chk("R10 no idle", n_idle - d0, 0);
    chk("R10 no idle wake", sleeping, 1);
    rx_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    t_basic10();
    t_ie_off();
    t_idle();
    t_false_start();
    t_ferr();
    t_addr11();
    t_sleep_idle();
    t_sleep_addr();
    t_disabled();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule